// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Unit

This block runs the fine-adjust phase of a digitally controlled potentiometer's two-wire control path. Once the command front end has acknowledged a step instruction (instruction nibble 0010, register field 00, pot field selecting the target), it pulses `arm_i` with the chosen pot index. From then on the bus clock acts as a step clock and the data line as a direction flag. Each SCL high pulse moves the selected wiper register by one tap. SDA high moves it toward the high terminal (+1), and SDA low moves it toward the low terminal (-1).

The unit reads the current wiper values of all pots from `wiper_cur_i`. For each accepted pulse it issues a one-cycle update (`upd_valid_o`, `upd_pot_o`, `upd_value_o`) that the owner of the wiper registers applies directly. Alongside the update it raises a step-up or step-down pulse whenever the value actually moves. The mode lasts until a start or stop condition is reported by the bus front end. The unit never drives SDA and creates no acknowledge slots. SCL and SDA arrive already synchronised to `clk`, and start and stop detection arrive as one-cycle pulses.

Top module: `wiper_step_unit`

## Requirements
- R1: In reset and in the first cycle after reset, `active_o`, `upd_valid_o`, `step_up_o` and `step_dn_o` are 0.
- R2: An `arm_i` pulse with no start or stop in the same cycle sets `active_o` in the next cycle and latches `arm_pot_i` as the target pot.
- R3: While active, an SCL high pulse during which SDA is 1 produces one update of the target pot to its current value plus one. The update appears one cycle after the clock in which SCL is first seen low, and `step_up_o` pulses with it.
- R4: While active, an SCL high pulse during which SDA is 0 produces one update to the current value minus one, with a `step_dn_o` pulse.
- R5: Any number of pulses may be clocked in any mix of directions, with exactly one update per pulse. Direction is sampled at the SCL rising edge.
- R6: Stepping up at all-ones or down at zero still issues an update, but with the value unchanged and no step pulse. The value never wraps.
- R7: A stop condition ends the mode. An SCL pulse that is high when the stop is reported produces no update.
- R8: A start condition ends the mode in the same way, with no step taken.
- R9: SCL pulses while the mode is inactive produce no update.
- R10: If start or stop coincides with `arm_i`, the start or stop wins and the mode is not entered.
- R11: A new `arm_i` pulse while active retargets the following steps to the new pot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse: step instruction acknowledged |
| arm_pot_i | input | PW = clog2(NPOTS) | Pot index carried by the step instruction |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (direction) |
| start_det_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_det_i | input | 1 | Stop condition seen (one-cycle pulse) |
| wiper_cur_i | input | NPOTS*WW | Current wiper values, pot 0 in the low bits |
| active_o | output | 1 | Step mode is active |
| upd_valid_o | output | 1 | One-cycle wiper update strobe |
| upd_pot_o | output | PW | Pot index of the update |
| upd_value_o | output | WW | New wiper value |
| step_up_o | output | 1 | Update moved the wiper up one tap |
| step_dn_o | output | 1 | Update moved the wiper down one tap |

## Verification
The hardest case to reach is the cancelled step. SCL has risen and a step is pending, but the pulse ends with a bus condition rather than an SCL fall, so the step must be dropped. The stimulus reaches this by building real stop and start sequences on the pins. For a stop, SDA is held low, SCL is raised, and SDA is then released together with the stop pulse. For a start, SCL rises with SDA high, and SDA then falls with the start pulse. Both are played inside an armed session. The saturating rails are reached by presetting wiper values one tap from each end.

// File: rtl/wsu_pkg.sv
// Shared types for the wiper step unit.
// Assumes: nothing beyond IEEE 1800-2017.
package wsu_pkg;

    // Step direction as sampled from the data line.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

endpackage

// File: rtl/wsu_edge.sv
// Edge finder for the synchronised bus clock.
// Assumes: scl_i is already synchronised to clk. The history register resets
// to 1 (idle bus) so that leaving reset never fakes a rising edge.
module wsu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q;

    // Keep last cycle's SCL level.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    // Decode the two transitions.
    always_comb begin
        rise_o = scl_i & ~scl_q;
        fall_o = ~scl_i & scl_q;
    end

endmodule

// File: rtl/wsu_mode_ctl.sv
// Session control: enters step mode on arm, leaves on any bus condition.
// Assumes: arm_i is a one-cycle pulse from the command front end. abort_i
// (start or stop) has priority over arm_i.
module wsu_mode_ctl #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [PW-1:0] arm_pot_i,
    input  logic          abort_i,
    output logic          active_o,
    output logic [PW-1:0] pot_o
);

    // Track session state and latch the target pot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            pot_o    <= '0;
        end else if (abort_i) begin
            active_o <= 1'b0;
        end else if (arm_i) begin
            active_o <= 1'b1;
            pot_o    <= arm_pot_i;
        end
    end

endmodule

// File: rtl/wsu_step_seq.sv
// Per-pulse sequencer: samples direction at SCL rise and commits at SCL fall.
// Assumes: start/stop can only occur while SCL is high. A bus condition seen
// between rise and fall therefore cancels the pending step.
module wsu_step_seq
    import wsu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active_i,
    input  logic      abort_i,
    input  logic      rise_i,
    input  logic      fall_i,
    input  logic      sda_i,
    output logic      commit_o,
    output step_dir_e dir_o
);

    logic pending;

    // Hold one pending step between the SCL rising and falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            dir_o   <= DIR_DOWN;
        end else if (!active_i || abort_i) begin
            pending <= 1'b0;
        end else if (rise_i) begin
            pending <= 1'b1;
            dir_o   <= step_dir_e'(sda_i);
        end else if (fall_i) begin
            pending <= 1'b0;
        end
    end

    // A step is taken only when the pulse closes cleanly inside the session.
    always_comb begin
        commit_o = pending & fall_i & active_i & ~abort_i;
    end

endmodule

// File: rtl/wsu_sat_step.sv
// Selects the target wiper and forms its saturated next value.
// Assumes: pot_i < NPOTS. Values are unsigned tap indices.
module wsu_sat_step
    import wsu_pkg::*;
#(
    parameter int NPOTS = 4,
    parameter int WW    = 8,
    parameter int PW    = 2
) (
    input  logic [NPOTS*WW-1:0] cur_flat_i,
    input  logic [PW-1:0]       pot_i,
    input  step_dir_e           dir_i,
    output logic [WW-1:0]       next_o,
    output logic                moved_o
);

    logic [WW-1:0] cur_arr [NPOTS];
    logic [WW-1:0] cur;
    logic          at_top;
    logic          at_bot;

    // Slice the flat bus into one word per pot.
    for (genvar g = 0; g < NPOTS; g++) begin : g_slice
        assign cur_arr[g] = cur_flat_i[g*WW +: WW];
    end

    // Pick the target and clamp at the rails.
    always_comb begin
        cur    = cur_arr[pot_i];
        at_top = (cur == '1);
        at_bot = (cur == '0);
        if (dir_i == DIR_UP) begin
            moved_o = ~at_top;
            next_o  = at_top ? cur : cur + WW'(1);
        end else begin
            moved_o = ~at_bot;
            next_o  = at_bot ? cur : cur - WW'(1);
        end
    end

endmodule

// File: rtl/wiper_step_unit.sv
// Top of the serial-clocked wiper step unit.
// Assumes: SCL/SDA synchronised to clk. Start/stop reported as one-cycle
// pulses. The wiper register owner applies upd_* on the cycle it is valid.
module wiper_step_unit
    import wsu_pkg::*;
#(
    parameter int  NPOTS = 4,
    parameter int  WW    = 8,
    localparam int PW    = (NPOTS > 1) ? $clog2(NPOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic [PW-1:0]       arm_pot_i,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                start_det_i,
    input  logic                stop_det_i,
    input  logic [NPOTS*WW-1:0] wiper_cur_i,
    output logic                active_o,
    output logic                upd_valid_o,
    output logic [PW-1:0]       upd_pot_o,
    output logic [WW-1:0]       upd_value_o,
    output logic                step_up_o,
    output logic                step_dn_o
);

    logic          abort;
    logic          rise;
    logic          fall;
    logic          commit;
    logic [PW-1:0] pot;
    step_dir_e     dir;
    logic [WW-1:0] next_val;
    logic          moved;

    // Any bus condition terminates the session.
    always_comb abort = start_det_i | stop_det_i;

    wsu_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    wsu_mode_ctl #(.PW(PW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .arm_pot_i (arm_pot_i),
        .abort_i   (abort),
        .active_o  (active_o),
        .pot_o     (pot)
    );

    wsu_step_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_o),
        .abort_i  (abort),
        .rise_i   (rise),
        .fall_i   (fall),
        .sda_i    (sda_i),
        .commit_o (commit),
        .dir_o    (dir)
    );

    wsu_sat_step #(.NPOTS(NPOTS), .WW(WW), .PW(PW)) u_sat (
        .cur_flat_i (wiper_cur_i),
        .pot_i      (pot),
        .dir_i      (dir),
        .next_o     (next_val),
        .moved_o    (moved)
    );

    // Register the update strobe and the step pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid_o <= 1'b0;
            upd_pot_o   <= '0;
            upd_value_o <= '0;
            step_up_o   <= 1'b0;
            step_dn_o   <= 1'b0;
        end else begin
            upd_valid_o <= commit;
            step_up_o   <= commit & moved & (dir == DIR_UP);
            step_dn_o   <= commit & moved & (dir == DIR_DOWN);
            if (commit) begin
                upd_pot_o   <= pot;
                upd_value_o <= next_val;
            end
        end
    end

endmodule

// File: rtl/wiper_step_unit_chk.sv
// Property checker for wiper_step_unit, bound to every instance.
// Assumes: same parameters as the bound instance.
module wiper_step_unit_chk #(
    parameter int WW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          start_det_i,
    input logic          stop_det_i,
    input logic          active_o,
    input logic          upd_valid_o,
    input logic [WW-1:0] upd_value_o,
    input logic          step_up_o,
    input logic          step_dn_o
);

    // R2: clean arm enters the session
    a_r2_arm_enters: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && !start_det_i && !stop_det_i |=> active_o);

    // R7: stop leaves the session
    a_r7_stop_exits: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det_i |=> !active_o);

    // R8: start leaves the session
    a_r8_start_exits: assert property (@(posedge clk) disable iff (!rst_n)
        start_det_i |=> !active_o);

    // R9: updates only come out of an active session
    a_r9_upd_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> $past(active_o));

    // R3: at most one direction pulse per cycle
    a_r3_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up_o, step_dn_o}));

    // R4: a step pulse always travels with an update
    a_r4_step_has_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o || step_dn_o) |-> upd_valid_o);

    // R6: a non-moving update sits on a rail
    a_r6_hold_at_rail: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o && !step_up_o && !step_dn_o |-> (upd_value_o == '1 || upd_value_o == '0));

    // R6: upward step never wraps to zero
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        step_up_o |-> upd_value_o != '0);

    // R6: downward step never wraps to all-ones
    a_r6_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn_o |-> upd_value_o != '1);

endmodule

bind wiper_step_unit wiper_step_unit_chk #(.WW(WW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .active_o    (active_o),
    .upd_valid_o (upd_valid_o),
    .upd_value_o (upd_value_o),
    .step_up_o   (step_up_o),
    .step_dn_o   (step_dn_o)
);

// File: tb/wiper_step_unit_tb_top.sv
// Self-checking bench with a behavioural per-cycle model of the step unit.
module wiper_step_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic [1:0]  arm_pot_i = '0;
    logic        scl_i = 1'b1;
    logic        sda_i = 1'b1;
    logic        start_det_i = 1'b0;
    logic        stop_det_i = 1'b0;
    logic [31:0] wiper_cur_i;
    logic        active_o, upd_valid_o, step_up_o, step_dn_o;
    logic [1:0]  upd_pot_o;
    logic [7:0]  upd_value_o;

    always #10 clk = ~clk;

    wiper_step_unit dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .arm_pot_i(arm_pot_i),
        .scl_i(scl_i), .sda_i(sda_i), .start_det_i(start_det_i),
        .stop_det_i(stop_det_i), .wiper_cur_i(wiper_cur_i),
        .active_o(active_o), .upd_valid_o(upd_valid_o), .upd_pot_o(upd_pot_o),
        .upd_value_o(upd_value_o), .step_up_o(step_up_o), .step_dn_o(step_dn_o)
    );

    // Model-owned wiper registers feed the design.
    logic [7:0] w [4];
    assign wiper_cur_i = {w[3], w[2], w[1], w[0]};

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model state.
    int m_active = 0, m_pot = 0, m_pend = 0, m_dir = 0, m_sclq = 1;
    int e_upd = 0, e_pot = 0, e_val = 0, e_up = 0, e_dn = 0;

    always @(posedge clk) begin
        int rise, fall, abrt, cur, nv;
        if (!rst_n) begin
            m_active = 0; m_pot = 0; m_pend = 0; m_dir = 0; m_sclq = 1;
            e_upd = 0; e_up = 0; e_dn = 0;
        end else begin
            rise = (scl_i && !m_sclq) ? 1 : 0;
            fall = (!scl_i && m_sclq) ? 1 : 0;
            abrt = (start_det_i || stop_det_i) ? 1 : 0;
            e_upd = 0; e_up = 0; e_dn = 0;
            if (m_pend != 0 && fall != 0 && m_active != 0 && abrt == 0) begin
                cur = int'(w[m_pot]);
                if (m_dir != 0) nv = (cur == 255) ? cur : cur + 1;
                else            nv = (cur == 0)   ? cur : cur - 1;
                e_upd = 1; e_pot = m_pot; e_val = nv;
                e_up = (m_dir != 0 && nv != cur) ? 1 : 0;
                e_dn = (m_dir == 0 && nv != cur) ? 1 : 0;
                w[m_pot] <= 8'(nv);
            end
            if (m_active == 0 || abrt != 0) m_pend = 0;
            else if (rise != 0) begin m_pend = 1; m_dir = sda_i ? 1 : 0; end
            else if (fall != 0) m_pend = 0;
            if (abrt != 0) m_active = 0;
            else if (arm_i) begin m_active = 1; m_pot = int'(arm_pot_i); end
            m_sclq = scl_i ? 1 : 0;
        end
    end

    // Design-observed wiper image and pulse counters.
    int dw [4];
    int n_upd = 0, n_sup = 0, n_sdn = 0;

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(active_o == (m_active != 0), {cur_req, " active"}, active_o, m_active);
            chk(upd_valid_o == (e_upd != 0), {cur_req, " upd_valid"}, upd_valid_o, e_upd);
            chk(step_up_o == (e_up != 0), {cur_req, " step_up"}, step_up_o, e_up);
            chk(step_dn_o == (e_dn != 0), {cur_req, " step_dn"}, step_dn_o, e_dn);
            if (e_upd != 0) begin
                chk(int'(upd_pot_o) == e_pot, {cur_req, " upd_pot"}, upd_pot_o, e_pot);
                chk(int'(upd_value_o) == e_val, {cur_req, " upd_value"}, upd_value_o, e_val);
            end
            if (upd_valid_o) begin
                dw[upd_pot_o] = int'(upd_value_o);
                n_upd++;
            end
            if (step_up_o) n_sup++;
            if (step_dn_o) n_sdn++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic arm(input int p);
        arm_i = 1'b1; arm_pot_i = 2'(p);
        tick(1);
        arm_i = 1'b0;
        tick(1);
    endtask

    task automatic pulse(input bit d);
        scl_i = 1'b0; tick(2);
        sda_i = d;    tick(2);
        scl_i = 1'b1; tick(4);
        scl_i = 1'b0; tick(3);
    endtask

    task automatic start_cond();
        scl_i = 1'b0; tick(1);
        sda_i = 1'b1; tick(1);
        scl_i = 1'b1; tick(2);
        sda_i = 1'b0; start_det_i = 1'b1; tick(1);
        start_det_i = 1'b0; tick(1);
        scl_i = 1'b0; tick(2);
    endtask

    task automatic stop_cond();
        scl_i = 1'b0; tick(1);
        sda_i = 1'b0; tick(2);
        scl_i = 1'b1; tick(3);
        sda_i = 1'b1; stop_det_i = 1'b1; tick(1);
        stop_det_i = 1'b0; tick(3);
    endtask

    // Directed check sampled at a falling edge.
    task automatic dchk(input string req, input int act, input int exp);
        @(negedge clk);
        chk(act == exp, req, act, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        w[0] = 8'h01; w[1] = 8'hFE; w[2] = 8'h80; w[3] = 8'h40;
        dw[0] = 1; dw[1] = 'hFE; dw[2] = 'h80; dw[3] = 'h40;
        tick(3);
        // R1: reset state
        chk(!active_o && !upd_valid_o && !step_up_o && !step_dn_o, "R1 reset outputs",
            {active_o, upd_valid_o, step_up_o, step_dn_o}, 0);
        rst_n = 1'b1;
        tick(1);
        dchk("R1 idle after reset", int'(active_o), 0);

        cur_req = "R9";
        pulse(1'b1); pulse(1'b0);
        dchk("R9 no update while idle", n_upd, 0);

        cur_req = "R2";
        start_cond();
        arm(2);
        dchk("R2 active after arm", int'(active_o), 1);

        cur_req = "R3";
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        dchk("R3 pot2 after three ups", dw[2], 'h83);
        cur_req = "R4";
        pulse(1'b0); pulse(1'b0);
        dchk("R4 pot2 after two downs", dw[2], 'h81);
        cur_req = "R5";
        pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b1); pulse(1'b1);
        dchk("R5 mixed steps net +1", dw[2], 'h82);
        dchk("R5 one update per pulse", n_upd, 10);

        cur_req = "R7";
        stop_cond();
        dchk("R7 stop exits", int'(active_o), 0);
        dchk("R7 stop pulse took no step", dw[2], 'h82);
        pulse(1'b1);
        dchk("R7 no step after stop", dw[2], 'h82);

        cur_req = "R6";
        start_cond();
        arm(1);
        n_sup = 0; n_upd = 0;
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        dchk("R6 pot1 clamps at FF", dw[1], 'hFF);
        dchk("R6 only one real up step", n_sup, 1);
        dchk("R6 every pulse still updates", n_upd, 3);
        start_cond();
        arm(0);
        n_sdn = 0;
        pulse(1'b0); pulse(1'b0);
        dchk("R6 pot0 clamps at 00", dw[0], 0);
        dchk("R6 only one real down step", n_sdn, 1);

        cur_req = "R8";
        start_cond();
        arm(3);
        scl_i = 1'b0; tick(1);
        sda_i = 1'b1; tick(1);
        scl_i = 1'b1; tick(2);
        sda_i = 1'b0; start_det_i = 1'b1; tick(1);
        start_det_i = 1'b0; tick(1);
        scl_i = 1'b0; tick(3);
        dchk("R8 start exits", int'(active_o), 0);
        dchk("R8 no step on cancelled pulse", dw[3], 'h40);

        cur_req = "R10";
        arm_i = 1'b1; arm_pot_i = 2'd3; stop_det_i = 1'b1;
        tick(1);
        arm_i = 1'b0; stop_det_i = 1'b0;
        dchk("R10 stop beats arm", int'(active_o), 0);
        pulse(1'b1);
        dchk("R10 no step", dw[3], 'h40);

        cur_req = "R11";
        arm(3);
        arm(0);
        pulse(1'b1);
        dchk("R11 retarget to pot0", dw[0], 1);
        dchk("R11 pot3 untouched", dw[3], 'h40);
        stop_cond();

        tick(5);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule